// File: doc/BRIEF.md
# Two-Register Serial Control Slave

This block is a two-wire serial bus slave that holds the control and status settings of a dual-output supply controller. A bus master writes one-byte commands. The top bit of each command byte chooses one of two 8-bit registers, and the remaining bits set that register's control fields. The first register carries a shared dynamic-limit mode and the settings for channel 0. The second register carries the settings for channel 1. Each channel has a current-limit range, a continuous-tone force, a cable-drop boost, a high-voltage select and an output enable. The decoded fields drive the power stages directly.

A read returns the registers in a fixed order, first register then second, and alternates between them for as long as the master acknowledges. Each read byte carries the live overload and over-temperature flags in its read-only positions. Both registers are held at zero while the power-good input is low, and the slave then acknowledges nothing. An over-temperature condition wipes every written field. SCL and SDA arrive as raw samples and are synchronized inside the block. The SDA output is a pull-low enable for an external open-drain pad.

Top module: `dual_reg_i2c_slave`

## Requirements
- R1: The slave responds only to the 7-bit address 000100A, where A is `addr_sel_i`. It acknowledges its own address in either direction. After any other address it acknowledges nothing, and the data bytes that follow change no setting.
- R2: A written byte (MSB first) with bit 7 = 0 updates the first register. Bits 6..1 become, in order, `dyn_lim_o`, `ilim_hi_o[0]`, `tone_on_o[0]`, `comp_up_o[0]`, `hi_volt_o[0]` and `chan_en_o[0]`. The second register is left unchanged.
- R3: A written byte with bit 7 = 1 updates the second register. Bits 6..2 become, in order, `ilim_hi_o[1]`, `tone_on_o[1]`, `comp_up_o[1]`, `hi_volt_o[1]` and `chan_en_o[1]`. The first register is left unchanged.
- R4: The read-only positions of a written byte change nothing. These are bit 0 when bit 7 = 0, and bits 1..0 when bit 7 = 1.
- R5: The slave pulls SDA low during the ninth clock after its matching address byte and after every data byte it receives. Any number of data bytes may follow one address.
- R6: A read returns the first register as {0, six control bits, `ovl1_i`}, then the second as {1, five control bits, `ovt_i`, `ovl2_i`}. The two alternate on each byte the master acknowledges. A not-acknowledge ends the read and releases SDA.
- R7: While `pwr_ok_i` is low, every control output is 0 and the slave acknowledges no address.
- R8: While `ovt_i` is high, every control output is cleared to 0 and incoming writes are discarded.
- R9: After reset, every control output is 0 and SDA is released.
- R10: A STOP in the middle of a byte abandons that byte without a write. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock sample |
| sda_i | input | 1 | Raw bus data sample |
| pwr_ok_i | input | 1 | Supply good; low holds registers cleared and the slave silent |
| addr_sel_i | input | 1 | Lowest slave address bit |
| ovl1_i | input | 1 | Channel 0 overload flag |
| ovl2_i | input | 1 | Channel 1 overload flag |
| ovt_i | input | 1 | Over-temperature flag |
| sda_pull_o | output | 1 | Drive SDA low when 1 |
| dyn_lim_o | output | 1 | Dynamic current-limit mode |
| ilim_hi_o | output | 2 | Per-channel high current-limit range |
| tone_on_o | output | 2 | Per-channel continuous tone force |
| comp_up_o | output | 2 | Per-channel cable-drop boost |
| hi_volt_o | output | 2 | Per-channel high output voltage select |
| chan_en_o | output | 2 | Per-channel enable |

## Verification
The hardest case to reach is a read whose bytes carry several live flag combinations while the write-side fields hold known, distinct values. The over-temperature flag both appears in the read data and wipes those fields. The stimulus therefore loops over all eight flag combinations. For each one it rewrites both registers with flag-dependent values, raises the flags, confirms any clearing, and then reads three bytes so that the alternation wraps back to the first register. Register decoding, including the read-only positions, is covered by streaming all 256 byte values through one long write transaction.

// File: rtl/drs_pkg.sv
package drs_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 4;
    localparam int REG0_CTL_W = 6;
    localparam int REG1_CTL_W = 5;
    localparam int CHAN_N    = 2;
    localparam int CHAN_CTL_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } bus_st_e;
endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;
    logic scl_s;

    assign scl_s   = q.scl[STAGES-1];
    assign sda_s_o = q.sda[STAGES-1];

    always_comb begin
        d       = q;
        d.scl   = {q.scl[STAGES-2:0], scl_i};
        d.sda   = {q.sda[STAGES-2:0], sda_i};
        d.scl_p = scl_s;
        d.sda_p = sda_s_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise_o = scl_s & ~q.scl_p;
    assign scl_fall_o = ~scl_s & q.scl_p;
    assign start_o    = scl_s & q.scl_p & q.sda_p & ~sda_s_o;
    assign stop_o     = scl_s & q.scl_p & ~q.sda_p & sda_s_o;

    // R10
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !stop_o);
endmodule

// File: rtl/drs_engine.sv
module drs_engine
    import drs_pkg::*;
#(
    parameter logic [5:0] ADDR_UPPER = 6'b000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok_i,
    input  logic              addr_sel_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] rd_byte0_i,
    input  logic [BYTE_W-1:0] rd_byte1_i,
    output logic              sda_pull_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_byte_o
);
    typedef struct packed {
        bus_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              rsel;
        logic              mack;
        logic              pull;
        logic              wr_stb;
        logic [BYTE_W-1:0] wr_byte;
    } eng_t;

    eng_t q, d;
    logic [BYTE_W-1:0] tx_next;

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;
        tx_next  = q.rsel ? rd_byte0_i : rd_byte1_i;
        if (!pwr_ok_i) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else if (start_i) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else if (stop_i) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == CNT_W'(BYTE_W)) begin
                        if (q.sh[BYTE_W-1:1] == {ADDR_UPPER, addr_sel_i}) begin
                            d.st   = ST_AACK;
                            d.pull = 1'b1;
                            d.rw   = q.sh[0];
                            d.rsel = 1'b0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st   = ST_RDAT;
                            d.sh   = rd_byte0_i;
                            d.pull = ~rd_byte0_i[BYTE_W-1];
                        end else begin
                            d.st   = ST_WDAT;
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_WDAT: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == CNT_W'(BYTE_W)) begin
                        d.wr_stb  = 1'b1;
                        d.wr_byte = q.sh;
                        d.st      = ST_WACK;
                        d.pull    = 1'b1;
                    end
                end
                ST_WACK: begin
                    if (scl_fall_i) begin
                        d.st   = ST_WDAT;
                        d.cnt  = '0;
                        d.pull = 1'b0;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == CNT_W'(BYTE_W)) begin
                            d.st   = ST_RACK;
                            d.pull = 1'b0;
                        end else begin
                            d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            d.pull = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_s_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.rsel = ~q.rsel;
                            d.st   = ST_RDAT;
                            d.cnt  = '0;
                            d.sh   = tx_next;
                            d.pull = ~tx_next[BYTE_W-1];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign wr_stb_o   = q.wr_stb;
    assign wr_byte_o  = q.wr_byte;

    // R7
    pwr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> !sda_pull_o);
    // R5
    pull_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> (q.st == ST_AACK || q.st == ST_WACK || q.st == ST_RDAT));
    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.st == ST_IDLE && !sda_pull_o));
    // R10
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && pwr_ok_i) |=> (q.st == ST_ADDR));
endmodule

// File: rtl/drs_regfile.sv
module drs_regfile
    import drs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_ok_i,
    input  logic                  ovt_i,
    input  logic                  ovl1_i,
    input  logic                  ovl2_i,
    input  logic                  wr_stb_i,
    input  logic [BYTE_W-1:0]     wr_byte_i,
    output logic [REG0_CTL_W-1:0] ctl0_o,
    output logic [REG1_CTL_W-1:0] ctl1_o,
    output logic [BYTE_W-1:0]     rd_byte0_o,
    output logic [BYTE_W-1:0]     rd_byte1_o
);
    typedef struct packed {
        logic [REG0_CTL_W-1:0] ctl0;
        logic [REG1_CTL_W-1:0] ctl1;
    } rf_t;

    rf_t q, d;
    logic unused_ro_bits;

    assign unused_ro_bits = ^wr_byte_i[1:0];

    always_comb begin
        d = q;
        if (!pwr_ok_i || ovt_i) begin
            d.ctl0 = '0;
            d.ctl1 = '0;
        end else if (wr_stb_i) begin
            if (wr_byte_i[BYTE_W-1]) d.ctl1 = wr_byte_i[BYTE_W-2 -: REG1_CTL_W];
            else                     d.ctl0 = wr_byte_i[BYTE_W-2 -: REG0_CTL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl0_o     = q.ctl0;
    assign ctl1_o     = q.ctl1;
    assign rd_byte0_o = {1'b0, q.ctl0, ovl1_i};
    assign rd_byte1_o = {1'b1, q.ctl1, ovt_i, ovl2_i};

    // R7
    pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> (ctl0_o == '0 && ctl1_o == '0));
    // R8
    ovt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovt_i |=> (ctl0_o == '0 && ctl1_o == '0));
    // R2
    reg0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && pwr_ok_i && !ovt_i && !wr_byte_i[BYTE_W-1])
        |=> (ctl0_o == $past(wr_byte_i[BYTE_W-2 -: REG0_CTL_W]) && $stable(ctl1_o)));
    // R3
    reg1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && pwr_ok_i && !ovt_i && wr_byte_i[BYTE_W-1])
        |=> (ctl1_o == $past(wr_byte_i[BYTE_W-2 -: REG1_CTL_W]) && $stable(ctl0_o)));
endmodule

// File: rtl/dual_reg_i2c_slave.sv
module dual_reg_i2c_slave
    import drs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_UPPER  = 6'b000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              pwr_ok_i,
    input  logic              addr_sel_i,
    input  logic              ovl1_i,
    input  logic              ovl2_i,
    input  logic              ovt_i,
    output logic              sda_pull_o,
    output logic              dyn_lim_o,
    output logic [CHAN_N-1:0] ilim_hi_o,
    output logic [CHAN_N-1:0] tone_on_o,
    output logic [CHAN_N-1:0] comp_up_o,
    output logic [CHAN_N-1:0] hi_volt_o,
    output logic [CHAN_N-1:0] chan_en_o
);
    logic sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic wr_stb;
    logic [BYTE_W-1:0] wr_byte, rd_byte0, rd_byte1;
    logic [REG0_CTL_W-1:0] ctl0;
    logic [REG1_CTL_W-1:0] ctl1;
    logic [CHAN_CTL_W-1:0] chan_ctl [CHAN_N];

    drs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_p),
        .stop_o     (stop_p)
    );

    drs_engine #(.ADDR_UPPER(ADDR_UPPER)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok_i   (pwr_ok_i),
        .addr_sel_i (addr_sel_i),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .rd_byte0_i (rd_byte0),
        .rd_byte1_i (rd_byte1),
        .sda_pull_o (sda_pull_o),
        .wr_stb_o   (wr_stb),
        .wr_byte_o  (wr_byte)
    );

    drs_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok_i   (pwr_ok_i),
        .ovt_i      (ovt_i),
        .ovl1_i     (ovl1_i),
        .ovl2_i     (ovl2_i),
        .wr_stb_i   (wr_stb),
        .wr_byte_i  (wr_byte),
        .ctl0_o     (ctl0),
        .ctl1_o     (ctl1),
        .rd_byte0_o (rd_byte0),
        .rd_byte1_o (rd_byte1)
    );

    assign dyn_lim_o   = ctl0[REG0_CTL_W-1];
    assign chan_ctl[0] = ctl0[CHAN_CTL_W-1:0];
    assign chan_ctl[1] = ctl1;

    for (genvar ch = 0; ch < CHAN_N; ch++) begin : g_chan
        assign ilim_hi_o[ch] = chan_ctl[ch][4];
        assign tone_on_o[ch] = chan_ctl[ch][3];
        assign comp_up_o[ch] = chan_ctl[ch][2];
        assign hi_volt_o[ch] = chan_ctl[ch][1];
        assign chan_en_o[ch] = chan_ctl[ch][0];
    end
endmodule

// File: tb/sim_dual_reg_i2c_slave.sv
`timescale 1ns/1ps
module sim_dual_reg_i2c_slave;
    localparam int QP = 10;
    localparam int WD_LIMIT = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic pwr_ok = 1'b1, addr_sel = 1'b0;
    logic ovl1 = 1'b0, ovl2 = 1'b0, ovt = 1'b0;
    logic sda_pull, dyn_lim;
    logic [1:0] ilim_hi, tone_on, comp_up, hi_volt, chan_en;
    logic sda_line;
    logic [5:0] m0;
    logic [4:0] m1;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    dual_reg_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .pwr_ok_i(pwr_ok), .addr_sel_i(addr_sel),
        .ovl1_i(ovl1), .ovl2_i(ovl2), .ovt_i(ovt),
        .sda_pull_o(sda_pull), .dyn_lim_o(dyn_lim), .ilim_hi_o(ilim_hi),
        .tone_on_o(tone_on), .comp_up_o(comp_up), .hi_volt_o(hi_volt),
        .chan_en_o(chan_en)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req);
        logic [5:0] o0;
        logic [4:0] o1;
        o0 = {dyn_lim, ilim_hi[0], tone_on[0], comp_up[0], hi_volt[0], chan_en[0]};
        o1 = {ilim_hi[1], tone_on[1], comp_up[1], hi_volt[1], chan_en[1]};
        chk({o0, o1} == {m0, m1}, req, int'({o0, o1}), int'({m0, m1}));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(QP);
        scl_m = 1'b1; wt(2*QP);
        sda_m = 1'b0; wt(2*QP);
        scl_m = 1'b0; wt(QP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(QP);
        scl_m = 1'b1; wt(2*QP);
        sda_m = 1'b1; wt(2*QP);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wt(QP);
        scl_m = 1'b1; wt(2*QP);
        scl_m = 1'b0; wt(QP);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wt(QP);
        scl_m = 1'b1; wt(QP);
        b = sda_line; wt(QP);
        scl_m = 1'b0; wt(QP);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~mack);
    endtask

    task automatic model_write(input logic [7:0] v);
        if (pwr_ok && !ovt) begin
            if (v[7]) m1 = v[6:2];
            else      m0 = v[6:1];
        end
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog actual=%0d cycles expected below %0d", WD_LIMIT, WD_LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rb, e0, e1b;
        m0 = '0;
        m1 = '0;
        wt(5);
        // R9: reset state
        chk_outs("R9 reset outputs");
        chk(sda_pull == 1'b0, "R9 sda released", int'(sda_pull), 0);
        rst_n = 1'b1;
        wt(5);

        // R7: no acknowledge while power is not good
        pwr_ok = 1'b0;
        wt(4);
        bus_start();
        send_byte(8'h10, ack);
        chk(ack == 1'b0, "R7 no ack when power low", int'(ack), 0);
        send_byte(8'h7E, ack);
        bus_stop();
        chk_outs("R7 outputs zero when power low");
        pwr_ok = 1'b1;
        wt(4);

        // R1: address matching
        bus_start(); send_byte(8'h12, ack); bus_stop();
        chk(ack == 1'b0, "R1 addr 0001001 rejected with sel=0", int'(ack), 0);
        bus_start(); send_byte(8'h20, ack);
        chk(ack == 1'b0, "R1 foreign address rejected", int'(ack), 0);
        send_byte(8'h7E, ack);
        bus_stop();
        chk_outs("R1 foreign address writes nothing");
        addr_sel = 1'b1;
        bus_start(); send_byte(8'h10, ack); bus_stop();
        chk(ack == 1'b0, "R1 addr 0001000 rejected with sel=1", int'(ack), 0);
        bus_start(); send_byte(8'h12, ack);
        chk(ack == 1'b1, "R1 addr 0001001 accepted with sel=1", int'(ack), 1);
        send_byte(8'h41, ack);
        model_write(8'h41);
        bus_stop();
        chk_outs("R1 R2 write after sel=1 address");
        addr_sel = 1'b0;

        // R2 R3 R4 R5: every byte value in one write transaction
        bus_start();
        send_byte(8'h10, ack);
        chk(ack == 1'b1, "R5 address ack", int'(ack), 1);
        for (int i = 0; i < 256; i++) begin
            send_byte(8'(i), ack);
            model_write(8'(i));
            chk(ack == 1'b1, "R5 data ack", int'(ack), 1);
            chk_outs(i[7] ? "R3 R4 second register decode" : "R2 R4 first register decode");
        end
        bus_stop();

        // R6 R8: reads under every flag combination
        for (int s = 0; s < 8; s++) begin
            e0 = {1'b0, 6'(s * 11 + 3), 1'b1};
            e1b = {1'b1, 5'(s * 7 + 9), 2'b11};
            bus_start();
            send_byte(8'h10, ack);
            send_byte(e0, ack);  model_write(e0);
            send_byte(e1b, ack); model_write(e1b);
            bus_stop();
            chk_outs("R2 R3 setup write");
            ovl1 = s[0];
            ovl2 = s[1];
            ovt  = s[2];
            wt(4);
            if (ovt) begin
                m0 = '0;
                m1 = '0;
                chk_outs("R8 over-temperature clears fields");
                bus_start();
                send_byte(8'h10, ack);
                send_byte(8'h7E, ack); model_write(8'h7E);
                send_byte(8'hFC, ack); model_write(8'hFC);
                bus_stop();
                chk_outs("R8 writes discarded during over-temperature");
            end
            bus_start();
            send_byte(8'h11, ack);
            chk(ack == 1'b1, "R1 R6 read address ack", int'(ack), 1);
            recv_byte(1'b1, rb);
            chk(rb == {1'b0, m0, ovl1}, "R6 first byte", int'(rb), int'({1'b0, m0, ovl1}));
            recv_byte(1'b1, rb);
            chk(rb == {1'b1, m1, ovt, ovl2}, "R6 second byte", int'(rb), int'({1'b1, m1, ovt, ovl2}));
            recv_byte(1'b0, rb);
            chk(rb == {1'b0, m0, ovl1}, "R6 wrap to first", int'(rb), int'({1'b0, m0, ovl1}));
            wt(QP);
            chk(sda_pull == 1'b0, "R6 released after nack", int'(sda_pull), 0);
            bus_stop();
            ovt = 1'b0;
            ovl1 = 1'b0;
            ovl2 = 1'b0;
            wt(4);
        end

        // R10: stop in mid-byte abandons the byte
        bus_start();
        send_byte(8'h10, ack);
        send_byte(8'h55, ack); model_write(8'h55);
        for (int i = 7; i >= 4; i--) bit_out(1'b1);
        bus_stop();
        chk_outs("R10 mid-byte stop writes nothing");
        // R10: repeated start into a read
        bus_start();
        send_byte(8'h10, ack);
        bus_start();
        send_byte(8'h11, ack);
        chk(ack == 1'b1, "R10 repeated start address ack", int'(ack), 1);
        recv_byte(1'b0, rb);
        chk(rb == {1'b0, m0, 1'b0}, "R10 read after repeated start", int'(rb), int'({1'b0, m0, 1'b0}));
        bus_stop();

        // R7: dropping power clears settings
        pwr_ok = 1'b0;
        wt(4);
        m0 = '0;
        m1 = '0;
        chk_outs("R7 power loss clears fields");
        pwr_ok = 1'b1;
        wt(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule